// File: doc/BRIEF.md
# Bus Node Power-Mode Sequencer

This block decides when a bus node listens, talks or sleeps. It has four modes. In receive-run the receiver is on. In transmit-run the transmitter is on and the receiver is off. In the two sleep modes everything is dark except for a short, regular window in which the receiver is switched on to sniff the line for a carrier.

A sleep command from the host interface logic takes the node into the dark mode and is acknowledged on the next clock. While the node sleeps, it leaves sleep in either of two ways:
- A carrier found during a listen window sends it back to receive-run and raises a one-cycle host wake pulse.
- Any edge on the host data line returns it to receive-run at once, because the host is already awake.

A transmit request moves the node from receive-run to transmit-run. A qualifier sampled with the request selects the extended preamble, which is used when the bus may be quiet and peers must be roused before the data starts.

The dark period and the listen window are parameters counted in system clock ticks. The defaults at a 200 MHz clock are 18 ms dark and 1 ms listening. The two asynchronous line inputs pass through a synchronizer whose depth is a parameter.

Top module: `bus_power_seq`

## Requirements
- R1: While reset is held and right after it, the node is in receive-run: `rx_en`=1, `tx_en`=0, `host_wake`=0, `sleep_ack`=0, `long_pre`=0.
- R2: A `sleep_cmd` seen in receive-run makes `sleep_ack` 1 for exactly the next cycle, with `rx_en` and `tx_en` both 0 from that same cycle.
- R3: After sleep entry, `rx_en` stays 0 for exactly `SLEEP_TICKS` cycles and then rises to open a listen window.
- R4: A listen window with no carrier lasts exactly `LISTEN_TICKS` cycles. The node then returns to the dark mode, and the dark/listen cycle repeats with `host_wake` held at 0.
- R5: A carrier seen during a listen window returns the node to receive-run and pulses `host_wake` for one cycle. This happens `SYNC_STAGES`+1 cycles after `carrier_det` rises.
- R6: `carrier_det` while the receiver is dark has no effect: no wake pulse, and the next listen window times out normally.
- R7: A rising or falling edge of `host_din` during the dark mode or a listen window returns the node to receive-run `SYNC_STAGES`+1 cycles later, without a `host_wake` pulse. The node then stays in receive-run.
- R8: `tx_req` in receive-run turns on `tx_en` and turns off `rx_en` on the next cycle. `long_pre` takes the value of `tx_wake` from the request cycle and holds it for the whole of transmit-run. When `tx_req` drops, the node returns to receive-run with `long_pre`=0.
- R9: `tx_en` and `rx_en` are never 1 in the same cycle.
- R10: `sleep_cmd` during transmit-run is ignored: there is no `sleep_ack`, `tx_en` stays on, and the node does not sleep after the transmission.
- R11: When `sleep_cmd` and `tx_req` come in the same receive-run cycle, the sleep command wins. A `tx_req` held while asleep does not enable the transmitter until the node is back in receive-run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_cmd | input | 1 | One-cycle sleep command from the host interface logic |
| host_din | input | 1 | Host data line level (asynchronous); any edge wakes the node |
| carrier_det | input | 1 | Bus carrier present (asynchronous) |
| tx_req | input | 1 | Transmit request, held high for the length of the transmission |
| tx_wake | input | 1 | Sampled with `tx_req`: 1 selects the extended wake preamble |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| host_wake | output | 1 | One-cycle pulse: bus activity woke the node |
| long_pre | output | 1 | Extended preamble select, valid while `tx_en` is 1 |
| sleep_ack | output | 1 | One-cycle acknowledge of an accepted sleep command |

## Verification
The bench counts the dark interval and the listen window edge by edge. A timer that is one tick off opens or closes the receiver a cycle early or late, and the bench reports it.

It wakes the node once with a rising and once with a falling host line edge, in the dark phase and inside a listen window. A detector that sees only one polarity, or only one phase, leaves `rx_en` low or drops back to sleep.

Other cases check that mode changes are exclusive and follow the stated priority:
- A carrier pulse that ends before the window opens must not wake the node.
- A sleep command during transmit-run must not be acknowledged.
- A sleep command arriving together with a transmit request must win.

A design that leaks any of these either pulses `sleep_ack` or `host_wake`, or enables the transmitter while asleep. Changing `tx_wake` in the middle of a transmission must leave `long_pre` unchanged.

// File: rtl/bps_pkg.sv
package bps_pkg;

    typedef enum logic [1:0] {
        MODE_RX     = 2'd0,
        MODE_TX     = 2'd1,
        MODE_DOZE   = 2'd2,
        MODE_LISTEN = 2'd3
    } pmode_e;

    typedef struct packed {
        pmode_e mode;
        logic   din_prev;
        logic   long_pre;
        logic   wake;
        logic   ack;
    } seq_state_t;

endpackage

// File: rtl/bps_sync.sv
module bps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bps_timer.sv
module bps_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [WIDTH-1:0] last,
    output logic             expired
);
    logic [WIDTH-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (restart)  count_d = '0;
        else if (run) count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign expired = run && (count_q == last);
endmodule

// File: rtl/bus_power_seq.sv
module bus_power_seq
    import bps_pkg::*;
#(
    parameter int SLEEP_TICKS  = 3_600_000,
    parameter int LISTEN_TICKS = 200_000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_cmd,
    input  logic host_din,
    input  logic carrier_det,
    input  logic tx_req,
    input  logic tx_wake,
    output logic rx_en,
    output logic tx_en,
    output logic host_wake,
    output logic long_pre,
    output logic sleep_ack
);
    localparam int MAX_TICKS = (SLEEP_TICKS > LISTEN_TICKS) ? SLEEP_TICKS : LISTEN_TICKS;
    localparam int TW        = $clog2(MAX_TICKS + 1);
    localparam logic [TW-1:0] SLEEP_LAST  = TW'(SLEEP_TICKS - 1);
    localparam logic [TW-1:0] LISTEN_LAST = TW'(LISTEN_TICKS - 1);

    seq_state_t st_d, st_q;
    pmode_e     mode_q;
    logic       din_s, carrier_s, din_edge;
    logic       tmr_restart, tmr_run, tmr_done;
    logic [TW-1:0] tmr_last;

    bps_sync #(.STAGES(SYNC_STAGES)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .d(host_din), .q(din_s)
    );

    bps_sync #(.STAGES(SYNC_STAGES)) u_sync_car (
        .clk(clk), .rst_n(rst_n), .d(carrier_det), .q(carrier_s)
    );

    // Dark and listen phases share one interval counter.
    assign tmr_run  = (st_q.mode == MODE_DOZE) || (st_q.mode == MODE_LISTEN);
    assign tmr_last = (st_q.mode == MODE_LISTEN) ? LISTEN_LAST : SLEEP_LAST;

    bps_timer #(.WIDTH(TW)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .restart(tmr_restart), .run(tmr_run),
        .last(tmr_last), .expired(tmr_done)
    );

    assign din_edge = din_s ^ st_q.din_prev;

    always_comb begin
        st_d          = st_q;
        st_d.wake     = 1'b0;
        st_d.ack      = 1'b0;
        st_d.din_prev = din_s;
        unique case (st_q.mode)
            MODE_RX: begin
                // Sleep has priority over a same-cycle transmit request.
                if (sleep_cmd) begin
                    st_d.mode = MODE_DOZE;
                    st_d.ack  = 1'b1;
                end else if (tx_req) begin
                    st_d.mode     = MODE_TX;
                    st_d.long_pre = tx_wake;
                end
            end
            MODE_TX: begin
                if (!tx_req) begin
                    st_d.mode     = MODE_RX;
                    st_d.long_pre = 1'b0;
                end
            end
            MODE_DOZE: begin
                if (din_edge)      st_d.mode = MODE_RX;
                else if (tmr_done) st_d.mode = MODE_LISTEN;
            end
            MODE_LISTEN: begin
                if (din_edge) begin
                    st_d.mode = MODE_RX;
                end else if (carrier_s) begin
                    st_d.mode = MODE_RX;
                    st_d.wake = 1'b1;
                end else if (tmr_done) begin
                    st_d.mode = MODE_DOZE;
                end
            end
            default: st_d.mode = MODE_RX;
        endcase
    end

    assign tmr_restart = (st_d.mode != st_q.mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_RX, din_prev: 1'b0, long_pre: 1'b0, wake: 1'b0, ack: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q    = st_q.mode;
    assign rx_en     = (st_q.mode == MODE_RX) || (st_q.mode == MODE_LISTEN);
    assign tx_en     = (st_q.mode == MODE_TX);
    assign host_wake = st_q.wake;
    assign long_pre  = st_q.long_pre;
    assign sleep_ack = st_q.ack;
endmodule

// File: rtl/bps_checker.sv
module bps_checker
    import bps_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   sleep_cmd,
    input logic   tx_req,
    input logic   rx_en,
    input logic   tx_en,
    input logic   host_wake,
    input logic   long_pre,
    input logic   sleep_ack,
    input pmode_e mode
);
    AST_RUN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en && rx_en)); // R9

    AST_SLEEP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RX && sleep_cmd) |=> sleep_ack); // R2

    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_ack |-> (!rx_en && !tx_en)); // R2

    AST_TX_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TX && sleep_cmd) |=> (!sleep_ack && tx_en)); // R10

    AST_WAKE_FROM_LISTEN: assert property (@(posedge clk) disable iff (!rst_n)
        host_wake |-> ($past(mode) == MODE_LISTEN && rx_en)); // R5

    AST_PRE_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        long_pre |-> tx_en); // R8

    AST_PRE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en)) |-> $stable(long_pre)); // R8

    AST_TX_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RX && tx_req && !sleep_cmd) |=> tx_en); // R8

    AST_SLEEP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RX && sleep_cmd && tx_req) |=> !tx_en); // R11
endmodule

bind bus_power_seq bps_checker u_bps_checker (
    .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .tx_req(tx_req),
    .rx_en(rx_en), .tx_en(tx_en), .host_wake(host_wake),
    .long_pre(long_pre), .sleep_ack(sleep_ack), .mode(mode_q)
);

// File: tb/tb_bus_power_seq.sv
`timescale 1ns/1ps
module tb_bus_power_seq;
    localparam int P = 20;
    localparam int L = 5;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_cmd = 1'b0, host_din = 1'b0, carrier_det = 1'b0;
    logic tx_req = 1'b0, tx_wake = 1'b0;
    logic rx_en, tx_en, host_wake, long_pre, sleep_ack;

    int checks = 0, failures = 0, wakes = 0, overlaps = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_power_seq #(.SLEEP_TICKS(P), .LISTEN_TICKS(L), .SYNC_STAGES(S)) dut (
        .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .host_din(host_din),
        .carrier_det(carrier_det), .tx_req(tx_req), .tx_wake(tx_wake),
        .rx_en(rx_en), .tx_en(tx_en), .host_wake(host_wake),
        .long_pre(long_pre), .sleep_ack(sleep_ack)
    );

    always @(negedge clk) begin
        if (rst_n && host_wake) wakes++;
        if (rst_n && tx_en && rx_en) overlaps++;
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic go_sleep();
        sleep_cmd = 1'b1;
        step(1);
        sleep_cmd = 1'b0;
        chk("R2", "sleep_ack after command", sleep_ack, 1);
        chk("R2", "rx_en off in sleep", rx_en, 0);
        chk("R2", "tx_en off in sleep", tx_en, 0);
    endtask

    task automatic t_reset();
        step(2);
        chk("R1", "rx_en in reset", rx_en, 1);
        chk("R1", "tx_en in reset", tx_en, 0);
        chk("R1", "host_wake in reset", host_wake, 0);
        chk("R1", "sleep_ack in reset", sleep_ack, 0);
        chk("R1", "long_pre in reset", long_pre, 0);
        rst_n = 1'b1;
        step(3);
        chk("R1", "rx_en after reset", rx_en, 1);
    endtask

    task automatic t_sleep_cycle();
        int w0 = wakes;
        go_sleep();
        step(1);
        chk("R2", "sleep_ack single pulse", sleep_ack, 0);
        step(P - 2);
        chk("R3", "rx_en dark at last sleep tick", rx_en, 0);
        step(1);
        chk("R3", "listen window opens", rx_en, 1);
        step(L - 1);
        chk("R4", "listen still open at last tick", rx_en, 1);
        step(1);
        chk("R4", "listen closes without carrier", rx_en, 0);
        step(P - 1);
        chk("R4", "second dark period", rx_en, 0);
        step(1);
        chk("R4", "second listen window", rx_en, 1);
        host_din = ~host_din;
        step(S + 1);
        chk("R7", "host edge in listen wakes", rx_en, 1);
        step(L + 2);
        chk("R7", "stays in receive-run", rx_en, 1);
        chk("R4", "no host_wake from quiet windows", wakes - w0, 0);
    endtask

    task automatic t_din_wake_dark();
        int w0 = wakes;
        go_sleep();
        step(3);
        host_din = ~host_din;
        step(S);
        chk("R7", "not yet awake before sync latency", rx_en, 0);
        step(1);
        chk("R7", "host edge in dark wakes", rx_en, 1);
        step(P + L);
        chk("R7", "stays awake after host edge", rx_en, 1);
        chk("R7", "no host_wake for host edge", wakes - w0, 0);
    endtask

    task automatic t_carrier_wake();
        int w0 = wakes;
        go_sleep();
        step(P);
        chk("R5", "listen open", rx_en, 1);
        carrier_det = 1'b1;
        step(S);
        chk("R5", "host_wake not early", host_wake, 0);
        step(1);
        chk("R5", "host_wake pulse", host_wake, 1);
        step(1);
        chk("R5", "host_wake one cycle", host_wake, 0);
        carrier_det = 1'b0;
        step(P + L);
        chk("R5", "stays in receive-run after wake", rx_en, 1);
        chk("R5", "exactly one wake pulse", wakes - w0, 1);
    endtask

    task automatic t_carrier_dark();
        int w0 = wakes;
        go_sleep();
        step(2);
        carrier_det = 1'b1;
        step(5);
        chk("R6", "carrier in dark keeps rx off", rx_en, 0);
        carrier_det = 1'b0;
        step(P - 7);
        chk("R6", "listen opens on schedule", rx_en, 1);
        step(L);
        chk("R6", "listen times out", rx_en, 0);
        chk("R6", "no host_wake from dark carrier", wakes - w0, 0);
        host_din = ~host_din;
        step(S + 1);
        chk("R7", "wake to leave scenario", rx_en, 1);
    endtask

    task automatic t_transmit();
        tx_wake = 1'b1;
        tx_req  = 1'b1;
        step(1);
        chk("R8", "tx_en on request", tx_en, 1);
        chk("R8", "rx_en off in transmit", rx_en, 0);
        chk("R8", "long preamble selected", long_pre, 1);
        tx_wake = 1'b0;
        step(3);
        chk("R8", "long_pre held in transmit", long_pre, 1);
        tx_req = 1'b0;
        step(1);
        chk("R8", "back to receive-run", rx_en, 1);
        chk("R8", "tx_en off after request", tx_en, 0);
        chk("R8", "long_pre cleared", long_pre, 0);
        tx_req = 1'b1;
        step(1);
        chk("R8", "short preamble selected", long_pre, 0);
        chk("R8", "tx_en on second request", tx_en, 1);
        sleep_cmd = 1'b1;
        step(1);
        sleep_cmd = 1'b0;
        chk("R10", "no ack during transmit", sleep_ack, 0);
        chk("R10", "transmit continues", tx_en, 1);
        tx_req = 1'b0;
        step(1);
        chk("R10", "receive-run after transmit", rx_en, 1);
        step(P + L);
        chk("R10", "did not sleep", rx_en, 1);
    endtask

    task automatic t_priority();
        sleep_cmd = 1'b1;
        tx_req    = 1'b1;
        step(1);
        sleep_cmd = 1'b0;
        chk("R11", "sleep wins ack", sleep_ack, 1);
        chk("R11", "sleep wins no tx", tx_en, 0);
        step(P / 2);
        chk("R11", "held tx_req ignored asleep", tx_en, 0);
        host_din = ~host_din;
        step(S + 1);
        chk("R11", "awake in receive-run", rx_en, 1);
        chk("R11", "not yet transmitting", tx_en, 0);
        step(1);
        chk("R11", "transmit after wake", tx_en, 1);
        tx_req = 1'b0;
        step(1);
        chk("R11", "back to receive-run", rx_en, 1);
    endtask

    initial begin
        t_reset();
        t_sleep_cycle();
        t_din_wake_dark();
        t_din_wake_dark();
        t_carrier_wake();
        t_carrier_dark();
        t_transmit();
        t_priority();
        chk("R9", "tx_en and rx_en overlap cycles", overlaps, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule